// File: doc/BRIEF.md
# Quadrature Encoder Position Counter

This block turns the two phase signals of an incremental encoder into a signed movement count. It keeps that count in a position register. Each input first passes through a synchroniser. It can then be exchanged with the other input and either input can be inverted. A decoder then produces a one-cycle count pulse and a direction. A 2-bit source-mode field picks the counting scheme:

- x4 quadrature, where every edge of either phase counts;
- pulse plus direction, where rising edges of A count and the level of B gives the direction;
- fixed up-only counting from A;
- fixed down-only counting from A.

In the two fixed modes, a separate bit makes both edges of A count instead of only the rising edge.

The decoder is built around a four-state phase machine. Its states are PH_00, PH_01, PH_10 and PH_11, named after the last conditioned {A,B} level pair. On every clock the machine moves to the current pair. A step to the neighbour along the forward Gray path is called FWD:

- PH_00 to PH_10
- PH_10 to PH_11
- PH_11 to PH_01
- PH_01 to PH_00

A step to the neighbour along the reverse path is called REV. Staying in place is HOLD. A diagonal jump, where both bits change at once, is called SKIP and produces no count.

Software reaches the block through a simple word bus. The bus has a write strobe and a combinational read. Through it, software reads the count, loads the count, and sets the initial value, the maximum value, the decoder fields and the counter enable. The counter wraps between 0 and the maximum value.

Top module: `qenc_pos_counter`

## Requirements
- R1: After reset, every register reads 0 except the maximum-value register, which reads all ones. The registers are position count at byte offset 0x00, initial value at 0x04, maximum value at 0x08, decoder control at 0x28 and main control at 0x2A.
- R2: With decoder-control bits 15:14 equal to 0 (quadrature), the following pairs are written as {A,B}:
  - Each FWD step of the conditioned phase adds 1 to the count: 00→10, 10→11, 11→01 or 01→00.
  - Each REV step subtracts 1.
  - The new count is readable 3 clock edges after the input edge is first sampled.
- R3: In quadrature mode, a SKIP (both A and B change in the same sample) and a HOLD leave the count unchanged.
- R4: With mode 1 (direction-count), only a rising edge of A counts. The count goes up if the new level of B is 1 and down if it is 0. Falling edges of A and any change of B alone leave the count unchanged.
- R5: With mode 2 (up-count) or mode 3 (down-count), B is ignored and A alone counts, up or down respectively. Decoder-control bit 11 at 0 counts only rising edges of A; at 1 both edges of A count.
- R6: The count changes on input edges only while main-control bit 3 is 1.
- R7: Counting up from the maximum value gives 0. Counting down from 0 gives the maximum value.
- R8: A write to the count register with a value above the maximum value is ignored. A write at or below it loads the count. A load wins over a count pulse in the same cycle.
- R9: A write to the initial-value register stores the value. If the value is at or below the maximum value, it also loads the count in the same cycle.
- R10: Decoder-control bit 10 exchanges A and B before decoding. Bit 8 inverts the A phase and bit 7 inverts the B phase before decoding.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| enc_a | input | 1 | Encoder phase A, asynchronous |
| enc_b | input | 1 | Encoder phase B, asynchronous |
| bus_addr | input | 8 | Register byte offset |
| bus_wdata | input | 32 | Write data |
| bus_we | input | 1 | Write strobe, one register per cycle |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| pos_count | output | 32 | Live position count |

## Verification
The hardest case to reach from the ports is a software load of the count that lands on exactly the clock edge where a decoded input edge would otherwise change the count. The bench counts the synchroniser and decoder registers in front of the counter. It changes A, then raises the write strobe so that it covers the second clock edge after that sample, and expects the written value rather than the incremented one.

Each of the 16 {A,B} before/after pairs is swept under every mode and edge setting. The count is reloaded to a midpoint before each transition, so every SKIP and HOLD is compared against an arithmetic model of the mode rules.

// File: rtl/qpc_pkg.sv
package qpc_pkg;
    localparam int ADDR_W = 8;

    localparam logic [ADDR_W-1:0] OFF_POS  = 8'h00;
    localparam logic [ADDR_W-1:0] OFF_INIT = 8'h04;
    localparam logic [ADDR_W-1:0] OFF_MAX  = 8'h08;
    localparam logic [ADDR_W-1:0] OFF_DEC  = 8'h28;
    localparam logic [ADDR_W-1:0] OFF_CTL  = 8'h2A;

    typedef enum logic [1:0] {
        SRC_QUAD = 2'd0,
        SRC_DIR  = 2'd1,
        SRC_UP   = 2'd2,
        SRC_DOWN = 2'd3
    } src_mode_e;

    // phase states, encoded as {A,B}
    typedef enum logic [1:0] {
        PH_00 = 2'b00,
        PH_01 = 2'b01,
        PH_10 = 2'b10,
        PH_11 = 2'b11
    } phase_e;
endpackage

// File: rtl/qpc_sync.sv
module qpc_sync #(
    parameter int WIDTH  = 2,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d_async,
    output logic [WIDTH-1:0] q_sync
);
    for (genvar g = 0; g < WIDTH; g++) begin : g_bit
        logic [STAGES-1:0] chain_q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain_q <= '0;
            else        chain_q <= {chain_q[STAGES-2:0], d_async[g]};
        end
        assign q_sync[g] = chain_q[STAGES-1];
    end
endmodule

// File: rtl/qpc_decode.sv
module qpc_decode
    import qpc_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      a_s,
    input  logic      b_s,
    input  src_mode_e mode,
    input  logic      both_edges,
    input  logic      swap_ab,
    input  logic      inv_a,
    input  logic      inv_b,
    output logic      step,
    output logic      count_up
);
    logic       a_c, b_c;
    phase_e     ph_q, ph_now;
    logic [1:0] q_bits;
    logic       fwd, rev, a_rise, a_fall;

    always_comb begin
        a_c    = (swap_ab ? b_s : a_s) ^ inv_a;
        b_c    = (swap_ab ? a_s : b_s) ^ inv_b;
        ph_now = phase_e'({a_c, b_c});
        q_bits = ph_q;
    end

    // state register: last conditioned phase
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ph_q <= PH_00;
        else        ph_q <= ph_now;
    end

    // transition classification: FWD, REV, else HOLD/SKIP
    always_comb begin
        fwd = 1'b0;
        rev = 1'b0;
        unique case (ph_q)
            PH_00: begin fwd = (ph_now == PH_10); rev = (ph_now == PH_01); end
            PH_10: begin fwd = (ph_now == PH_11); rev = (ph_now == PH_00); end
            PH_11: begin fwd = (ph_now == PH_01); rev = (ph_now == PH_10); end
            PH_01: begin fwd = (ph_now == PH_00); rev = (ph_now == PH_11); end
            default: ;
        endcase
    end

    assign a_rise = a_c & ~q_bits[1];
    assign a_fall = ~a_c & q_bits[1];

    // outputs per source mode
    always_comb begin
        step     = 1'b0;
        count_up = 1'b1;
        unique case (mode)
            SRC_QUAD: begin step = fwd | rev; count_up = fwd; end
            SRC_DIR:  begin step = a_rise;    count_up = b_c; end
            SRC_UP:   begin step = a_rise | (both_edges & a_fall); count_up = 1'b1; end
            SRC_DOWN: begin step = a_rise | (both_edges & a_fall); count_up = 1'b0; end
            default: ;
        endcase
    end

    p_skip_no_count_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == SRC_QUAD && a_c != q_bits[1] && b_c != q_bits[0]) |-> !step);

    p_b_ignored_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ((mode == SRC_UP || mode == SRC_DOWN) && a_c == q_bits[1]) |-> !step);
endmodule

// File: rtl/qpc_counter.sv
module qpc_counter #(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             step,
    input  logic             up,
    input  logic [CNT_W-1:0] max_val,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic [CNT_W-1:0] cnt_q
);
    localparam logic [CNT_W-1:0] ONE = {{(CNT_W-1){1'b0}}, 1'b1};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)          cnt_q <= '0;
        else if (load)       cnt_q <= load_val;
        else if (en && step) begin
            if (up) cnt_q <= (cnt_q == max_val) ? '0 : cnt_q + ONE;
            else    cnt_q <= (cnt_q == '0) ? max_val : cnt_q - ONE;
        end
    end

    p_wrap_up_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && en && step && up && cnt_q == max_val) |=> cnt_q == '0);

    p_wrap_down_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && en && step && !up && cnt_q == '0) |=> cnt_q == $past(max_val));

    p_hold_disabled_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && !en) |=> $stable(cnt_q));
endmodule

// File: rtl/qenc_pos_counter.sv
module qenc_pos_counter
    import qpc_pkg::*;
#(
    parameter int CNT_W       = 32,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enc_a,
    input  logic              enc_b,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [CNT_W-1:0]  bus_wdata,
    input  logic              bus_we,
    output logic [CNT_W-1:0]  bus_rdata,
    output logic [CNT_W-1:0]  pos_count
);
    localparam int PAD16 = CNT_W - 16;

    logic [CNT_W-1:0] init_q, max_q;
    src_mode_e        mode_q;
    logic             both_q, swap_q, inva_q, invb_q, en_q;
    logic [1:0]       ab_s;
    logic             step, count_up;
    logic             wr_pos, wr_init, in_range, load;
    logic [15:0]      dec_view, ctl_view;

    qpc_sync #(.WIDTH(2), .STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .d_async({enc_a, enc_b}), .q_sync(ab_s)
    );

    qpc_decode u_dec (
        .clk(clk), .rst_n(rst_n), .a_s(ab_s[1]), .b_s(ab_s[0]),
        .mode(mode_q), .both_edges(both_q), .swap_ab(swap_q),
        .inv_a(inva_q), .inv_b(invb_q), .step(step), .count_up(count_up)
    );

    always_comb begin
        wr_pos   = bus_we && (bus_addr == OFF_POS);
        wr_init  = bus_we && (bus_addr == OFF_INIT);
        in_range = (bus_wdata <= max_q);
        load     = (wr_pos || wr_init) && in_range;
    end

    qpc_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk(clk), .rst_n(rst_n), .en(en_q), .step(step), .up(count_up),
        .max_val(max_q), .load(load), .load_val(bus_wdata), .cnt_q(pos_count)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            init_q <= '0;
            max_q  <= '1;
            mode_q <= SRC_QUAD;
            both_q <= 1'b0;
            swap_q <= 1'b0;
            inva_q <= 1'b0;
            invb_q <= 1'b0;
            en_q   <= 1'b0;
        end else if (bus_we) begin
            unique case (bus_addr)
                OFF_INIT: init_q <= bus_wdata;
                OFF_MAX:  max_q  <= bus_wdata;
                OFF_DEC: begin
                    mode_q <= src_mode_e'(bus_wdata[15:14]);
                    both_q <= bus_wdata[11];
                    swap_q <= bus_wdata[10];
                    inva_q <= bus_wdata[8];
                    invb_q <= bus_wdata[7];
                end
                OFF_CTL:  en_q <= bus_wdata[3];
                default: ;
            endcase
        end
    end

    always_comb begin
        dec_view = {mode_q, 2'b00, both_q, swap_q, 1'b0, inva_q, invb_q, 7'b0};
        ctl_view = {12'b0, en_q, 3'b0};
        unique case (bus_addr)
            OFF_POS:  bus_rdata = pos_count;
            OFF_INIT: bus_rdata = init_q;
            OFF_MAX:  bus_rdata = max_q;
            OFF_DEC:  bus_rdata = {{PAD16{1'b0}}, dec_view};
            OFF_CTL:  bus_rdata = {{PAD16{1'b0}}, ctl_view};
            default:  bus_rdata = '0;
        endcase
    end

    p_ignore_big_write_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_pos && bus_wdata > max_q && !(en_q && step)) |=> $stable(pos_count));

    p_init_loads_count_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_init && bus_wdata <= max_q) |=> pos_count == $past(bus_wdata));
endmodule

// File: tb/test_qenc_pos_counter.sv
module test_qenc_pos_counter;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        enc_a = 1'b0, enc_b = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic        bus_we = 1'b0;
    logic [31:0] bus_rdata, pos_count;
    int          errors = 0, checks = 0;
    bit          done = 1'b0;

    always #10 clk = ~clk;

    qenc_pos_counter i_qenc_pos_counter (
        .clk(clk), .rst_n(rst_n), .enc_a(enc_a), .enc_b(enc_b),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_we(bus_we),
        .bus_rdata(bus_rdata), .pos_count(pos_count)
    );

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wr(logic [7:0] a, logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_we = 1'b1;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rd(logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = a;
        #1 d = bus_rdata;
    endtask

    task automatic drive(logic [1:0] ab);
        @(negedge clk);
        enc_a = ab[1]; enc_b = ab[0];
        repeat (4) @(negedge clk);
    endtask

    function automatic int gidx(logic [1:0] ab);
        case (ab)
            2'b00: return 0;
            2'b10: return 1;
            2'b11: return 2;
            default: return 3;
        endcase
    endfunction

    // expected change of the count for one {A,B} transition
    function automatic int delta(int m, bit x, logic [1:0] p, logic [1:0] n);
        bit rise = !p[1] && n[1];
        bit fall = p[1] && !n[1];
        int d;
        case (m)
            0: begin
                d = (gidx(n) - gidx(p) + 4) % 4;
                return (d == 1) ? 1 : (d == 3) ? -1 : 0;
            end
            1: return rise ? (n[0] ? 1 : -1) : 0;
            2: return (rise || (x && fall)) ? 1 : 0;
            default: return (rise || (x && fall)) ? -1 : 0;
        endcase
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset values
        rd(8'h00, v); check("R1 count", v, 0);
        rd(8'h04, v); check("R1 init", v, 0);
        rd(8'h08, v); check("R1 max", v, 32'hFFFF_FFFF);
        rd(8'h28, v); check("R1 dec", v, 0);
        rd(8'h2A, v); check("R1 ctl", v, 0);

        wr(8'h2A, 32'h8);
        rd(8'h2A, v); check("R6 ctl readback", v, 32'h8);

        // R2 R3 R4 R5 sweep over modes, edge select and all 16 transitions
        for (int m = 0; m < 4; m++) begin
            for (int x = 0; x < 2; x++) begin
                wr(8'h28, (m << 14) | (x << 11));
                for (int p = 0; p < 4; p++) begin
                    for (int n = 0; n < 4; n++) begin
                        drive(2'(p));
                        wr(8'h00, 100);
                        drive(2'(n));
                        rd(8'h00, v);
                        check($sformatf("R2/R3/R4/R5 m=%0d x=%0d %0d->%0d", m, x, p, n),
                              v, 32'(100 + delta(m, x, 2'(p), 2'(n))));
                    end
                end
            end
        end

        // R10 swap: physical B rises first counts up when swapped
        wr(8'h28, 32'h0400);
        drive(2'b00); wr(8'h00, 100);
        drive(2'b01);
        rd(8'h00, v); check("R10 swap", v, 101);

        // R10 invert A: physical A rise becomes a conditioned fall, 10->00 REV
        wr(8'h28, 32'h0100);
        drive(2'b00); wr(8'h00, 100);
        drive(2'b10);
        rd(8'h00, v); check("R10 invert A", v, 99);

        // R10 invert B: physical 00 reads as 01; A rise gives 01->11 REV
        wr(8'h28, 32'h0080);
        drive(2'b00); wr(8'h00, 100);
        drive(2'b10);
        rd(8'h00, v); check("R10 invert B", v, 99);

        // R6 disabled counter holds
        wr(8'h28, 32'h8000);
        drive(2'b00); wr(8'h00, 40);
        wr(8'h2A, 32'h0);
        drive(2'b10);
        rd(8'h00, v); check("R6 disabled", v, 40);
        wr(8'h2A, 32'h8);

        // R7 wrap up and down with max 5
        wr(8'h08, 5);
        drive(2'b00); wr(8'h00, 5);
        drive(2'b10);
        rd(8'h00, v); check("R7 wrap up", v, 0);
        wr(8'h28, 32'hC000);
        drive(2'b00); wr(8'h00, 0);
        drive(2'b10);
        rd(8'h00, v); check("R7 wrap down", v, 5);

        // R8 out-of-range write ignored, in-range loads
        wr(8'h00, 6);
        rd(8'h00, v); check("R8 big write ignored", v, 5);
        wr(8'h00, 2);
        rd(8'h00, v); check("R8 in-range write", v, 2);

        // R9 init write loads count; out of range only stores
        wr(8'h04, 3);
        rd(8'h00, v); check("R9 init loads count", v, 3);
        rd(8'h04, v); check("R9 init readback", v, 3);
        wr(8'h04, 9);
        rd(8'h00, v); check("R9 big init no load", v, 3);
        rd(8'h04, v); check("R9 big init stored", v, 9);

        // R8 load coincides with a counted edge: load wins
        wr(8'h08, 32'hFFFF_FFFF);
        wr(8'h28, 32'h8000);
        drive(2'b00); wr(8'h00, 50);
        @(negedge clk); enc_a = 1'b1;
        @(posedge clk); @(negedge clk); @(posedge clk);
        @(negedge clk); bus_addr = 8'h00; bus_wdata = 7; bus_we = 1'b1;
        @(negedge clk); bus_we = 1'b0;
        repeat (3) @(negedge clk);
        rd(8'h00, v); check("R8 load wins over step", v, 7);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule